// File: doc/BRIEF.md
# Cell-Partitioned Shared Cache

This block is a set-associative cache shared by four cores in which capacity is handed out in cells instead of whole ways. The set index range is cut into equal groups of consecutive indices, and every pairing of one way with one index group is a cell that belongs to exactly one core. A core may hit in, or fill into, only those ways whose cell for the current index group it owns. A core can therefore hold a way in one part of the index range while other cores use the same way elsewhere.

Requests arrive one at a time, each carrying a core number and a block address. The set index is the address modulo the set count, and the remaining upper bits form the tag. On a miss the least recently used way among the requester's ways is refilled at once, because main memory is treated as an immediate fill. If the requester owns no way in that index group, the access is answered as an uncached miss and nothing is stored. A write port reassigns any cell to any core. Per-core hit and miss counters let an external allocation controller judge how each core is using its share.

The request path is a three-state sequence. IDLE accepts a request (transition ACCEPT to LOOKUP). LOOKUP compares tags, chooses a victim and updates the arrays (transition RESOLVE to DONE). DONE presents the response for one cycle (transition RELEASE back to IDLE).

Top module: `cellc_shared_cache`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and every hit and miss counter reads 0. All lines start invalid.
- R2: For block address `a`, the set index is `a mod SETS` (the low bits), the tag is `a / SETS`, and the index group is `index / (SETS/GROUPS)`. With the defaults, indices 0..15 form group 0 and 16..31 form group 1.
- R3: A hit requires a valid line with a matching tag in a way whose cell for the current group the requester owns. The response has `resp_hit`=1, `resp_uncached`=0 and `resp_way` set to the lowest-numbered such way. A line held in another core's cell never hits.
- R4: On a miss where the requester owns at least one way in the group, the lowest-numbered invalid owned way is filled. If every owned way is valid, the least recently used owned way is filled instead. Both hits and fills count as uses. The response has `resp_hit`=0, `resp_uncached`=0 and `resp_way` set to the filled way.
- R5: If the requester owns no way in the group, the response has `resp_uncached`=1 and `resp_hit`=0, and no line is written, so repeating the access gives the same result.
- R6: An ownership write (`own_we` with group, way and core) applies to every request accepted on a later cycle. It does not invalidate the line in that cell, so the new owner can hit on it.
- R7: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the next two cycles. `resp_valid` is 1 for exactly one cycle, two cycles after acceptance, and `resp_core` echoes the requesting core.
- R8: Each response adds one to the requester's hit counter if it is a hit, and otherwise adds one to its miss counter. Uncached misses count as misses. Core c occupies bits [c*CNT_W +: CNT_W] of `hit_cnt` and of `miss_cnt`.
- R9: At reset, way w is owned by core w/(WAYS/CORES) in every group. With the defaults, ways 0-1 belong to core 0 and ways 6-7 to core 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_core | input | 2 | Requesting core |
| req_addr | input | ADDR_W (16) | Block address |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_core | output | 2 | Core that the response belongs to |
| resp_hit | output | 1 | Access hit |
| resp_uncached | output | 1 | Requester owns no way in the group |
| resp_way | output | 3 | Way that hit or was filled |
| own_we | input | 1 | Ownership write enable |
| own_group | input | 2 | Index group of the cell to write |
| own_way | input | 3 | Way of the cell to write |
| own_core | input | 2 | New owner of the cell |
| hit_cnt | output | CORES*CNT_W (64) | Per-core hit counters |
| miss_cnt | output | CORES*CNT_W (64) | Per-core miss counters |

## Verification
Directed sequences come first. A repeated address from one core separates hits from fills. The same address from a different core shows that lines in another core's cells are isolated. Three tags in a set where the core owns two ways separate true LRU from a fixed victim choice. Accesses at indices 15 and 16 land in different groups, which exposes a wrong group boundary. Handing a filled cell to another core shows that ownership changes keep the stored line, and stripping a core of every way in a group drives it into the uncached path. A long seeded random run then mixes ownership writes with accesses over a small tag range, so that hits, duplicate tags after a handover and LRU evictions all occur often; every response is compared against a bench model that orders ways by last-use time stamps.

// File: rtl/cellc_pkg.sv
package cellc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_DONE   = 2'd2
    } cc_state_t;

endpackage

// File: rtl/cellc_own_table.sv
module cellc_own_table #(
    parameter int GROUPS = 4,
    parameter int WAYS   = 8,
    parameter int CORES  = 4,
    localparam int GRP_W = $clog2(GROUPS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CORE_W = $clog2(CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GRP_W-1:0]  wr_group,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [CORE_W-1:0] wr_core,
    input  logic [GRP_W-1:0]  rd_group,
    input  logic [CORE_W-1:0] rd_core,
    output logic [WAYS-1:0]   eligible
);
    localparam int WAYS_PER_CORE = (WAYS >= CORES) ? WAYS / CORES : 1;

    logic [CORE_W-1:0] owner_q [GROUPS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < GROUPS; g++)
                for (int w = 0; w < WAYS; w++)
                    owner_q[g][w] <= CORE_W'((w / WAYS_PER_CORE) % CORES);
        end else if (wr_en) begin
            owner_q[wr_group][wr_way] <= wr_core;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_elig
        assign eligible[w] = (owner_q[rd_group][w] == rd_core);
    end

endmodule

// File: rtl/cellc_victim_pick.sv
module cellc_victim_pick #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       eligible,
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*WAY_W-1:0] ages,
    output logic                  found,
    output logic [WAY_W-1:0]      way
);
    logic             inv_found;
    logic             old_found;
    logic [WAY_W-1:0] best_age;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] old_way;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        old_found = 1'b0;
        old_way   = '0;
        best_age  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eligible[w] && !valid[w] && !inv_found) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
            if (eligible[w] && (!old_found || ages[w*WAY_W +: WAY_W] > best_age)) begin
                old_found = 1'b1;
                best_age  = ages[w*WAY_W +: WAY_W];
                old_way   = WAY_W'(w);
            end
        end
        found = inv_found | old_found;
        way   = inv_found ? inv_way : old_way;
    end

endmodule

// File: rtl/cellc_perf_counters.sv
module cellc_perf_counters #(
    parameter int CORES = 4,
    parameter int CNT_W = 16,
    localparam int CORE_W = $clog2(CORES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc_en,
    input  logic [CORE_W-1:0]      inc_core,
    input  logic                   inc_hit,
    output logic [CORES*CNT_W-1:0] hit_cnt,
    output logic [CORES*CNT_W-1:0] miss_cnt
);
    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic [CNT_W-1:0] hits_q;
        logic [CNT_W-1:0] misses_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hits_q   <= '0;
                misses_q <= '0;
            end else if (inc_en && inc_core == CORE_W'(c)) begin
                if (inc_hit) hits_q   <= hits_q + 1'b1;
                else         misses_q <= misses_q + 1'b1;
            end
        end

        assign hit_cnt[c*CNT_W +: CNT_W]  = hits_q;
        assign miss_cnt[c*CNT_W +: CNT_W] = misses_q;
    end

endmodule

// File: rtl/cellc_shared_cache.sv
module cellc_shared_cache #(
    parameter int CORES  = 4,
    parameter int WAYS   = 8,
    parameter int SETS   = 64,
    parameter int GROUPS = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int CORE_W = $clog2(CORES),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [CORE_W-1:0]      req_core,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   resp_valid,
    output logic [CORE_W-1:0]      resp_core,
    output logic                   resp_hit,
    output logic                   resp_uncached,
    output logic [WAY_W-1:0]       resp_way,
    input  logic                   own_we,
    input  logic [GRP_W-1:0]       own_group,
    input  logic [WAY_W-1:0]       own_way,
    input  logic [CORE_W-1:0]      own_core,
    output logic [CORES*CNT_W-1:0] hit_cnt,
    output logic [CORES*CNT_W-1:0] miss_cnt
);
    import cellc_pkg::*;

    cc_state_t state_q, state_d;

    logic [CORE_W-1:0] core_q;
    logic [ADDR_W-1:0] addr_q;
    logic              res_hit_q, res_unc_q;
    logic [WAY_W-1:0]  res_way_q;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic              valid_q [SETS][WAYS];
    logic [WAY_W-1:0]  age_q   [SETS][WAYS];

    // Address split: low bits index, top index bits select the group.
    logic [IDX_W-1:0] set_idx;
    logic [GRP_W-1:0] grp_idx;
    logic [TAG_W-1:0] tag_in;
    assign set_idx = addr_q[IDX_W-1:0];
    assign grp_idx = set_idx[IDX_W-1 -: GRP_W];
    assign tag_in  = addr_q[ADDR_W-1:IDX_W];

    logic [WAYS-1:0]       eligible;
    logic [WAYS-1:0]       set_valid;
    logic [WAYS*WAY_W-1:0] set_ages;
    logic [WAYS-1:0]       match;

    cellc_own_table #(.GROUPS(GROUPS), .WAYS(WAYS), .CORES(CORES)) own_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (own_we),
        .wr_group (own_group),
        .wr_way   (own_way),
        .wr_core  (own_core),
        .rd_group (grp_idx),
        .rd_core  (core_q),
        .eligible (eligible)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_valid[w]               = valid_q[set_idx][w];
        assign set_ages[w*WAY_W +: WAY_W] = age_q[set_idx][w];
        assign match[w] = eligible[w] && valid_q[set_idx][w]
                          && (tag_q[set_idx][w] == tag_in);
    end

    logic             victim_found;
    logic [WAY_W-1:0] victim_way;

    cellc_victim_pick #(.WAYS(WAYS)) pick_i (
        .eligible (eligible),
        .valid    (set_valid),
        .ages     (set_ages),
        .found    (victim_found),
        .way      (victim_way)
    );

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    logic             touch;
    logic [WAY_W-1:0] use_way;
    logic [WAY_W-1:0] use_age;
    assign touch   = (state_q == ST_LOOKUP) && (hit || victim_found);
    assign use_way = hit ? hit_way : victim_way;
    assign use_age = age_q[set_idx][use_way];

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;   // ACCEPT
            ST_LOOKUP: state_d = ST_DONE;                    // RESOLVE
            ST_DONE:   state_d = ST_IDLE;                    // RELEASE
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and request/result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            core_q    <= '0;
            addr_q    <= '0;
            res_hit_q <= 1'b0;
            res_unc_q <= 1'b0;
            res_way_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                core_q <= req_core;
                addr_q <= req_addr;
            end
            if (state_q == ST_LOOKUP) begin
                res_hit_q <= hit;
                res_unc_q <= !hit && !victim_found;
                res_way_q <= use_way;
            end
        end
    end

    // Tag, valid and age arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    age_q[s][w]   <= WAY_W'(w);
                end
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == use_way)
                    age_q[set_idx][w] <= '0;
                else if (age_q[set_idx][w] < use_age)
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
            if (!hit) begin
                valid_q[set_idx][use_way] <= 1'b1;
                tag_q[set_idx][use_way]   <= tag_in;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready  = 1'b1;
            ST_LOOKUP: req_ready  = 1'b0;
            ST_DONE:   resp_valid = 1'b1;
            default:   req_ready  = 1'b0;
        endcase
        resp_core     = core_q;
        resp_hit      = res_hit_q;
        resp_uncached = res_unc_q;
        resp_way      = res_way_q;
    end

    cellc_perf_counters #(.CORES(CORES), .CNT_W(CNT_W)) perf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (resp_valid),
        .inc_core (resp_core),
        .inc_hit  (resp_hit),
        .hit_cnt  (hit_cnt),
        .miss_cnt (miss_cnt)
    );

endmodule

// File: rtl/cellc_checker.sv
module cellc_checker #(
    parameter int CORES = 4,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   resp_valid,
    input logic                   resp_hit,
    input logic                   resp_uncached,
    input logic [CORES*CNT_W-1:0] hit_cnt,
    input logic [CORES*CNT_W-1:0] miss_cnt
);
    function automatic logic [CNT_W-1:0] total(input logic [CORES*CNT_W-1:0] h,
                                               input logic [CORES*CNT_W-1:0] m);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int c = 0; c < CORES; c++)
            acc = acc + h[c*CNT_W +: CNT_W] + m[c*CNT_W +: CNT_W];
        return acc;
    endfunction

    logic [CNT_W-1:0] sum_now;
    assign sum_now = total(hit_cnt, miss_cnt);

    // R7: response follows acceptance by two cycles
    a_r7_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    // R7: no new request is taken while a response is out
    a_r7_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R7: response strobe lasts a single cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R5: uncached answers are never hits
    a_r5_uncached_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_hit && resp_uncached));

    // R8: every response bumps exactly one counter
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> sum_now == $past(sum_now) + 1'b1);

    // R8: counters hold without a response
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |=> $stable(sum_now));

endmodule

bind cellc_shared_cache cellc_checker #(.CORES(CORES), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_uncached (resp_uncached),
    .hit_cnt       (hit_cnt),
    .miss_cnt      (miss_cnt)
);

// File: tb/cellc_shared_cache_tb_top.sv
module cellc_shared_cache_tb_top;
    localparam int CORES = 4, WAYS = 8, SETS = 64, GROUPS = 4, ADDR_W = 16, CNT_W = 16;
    localparam int PER_GRP = SETS / GROUPS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_core = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic [1:0]        resp_core;
    logic              resp_hit, resp_uncached;
    logic [2:0]        resp_way;
    logic              own_we = 1'b0;
    logic [1:0]        own_group = '0;
    logic [2:0]        own_way = '0;
    logic [1:0]        own_core = '0;
    logic [CORES*CNT_W-1:0] hit_cnt, miss_cnt;

    always #4 clk = ~clk;   // 125 MHz

    cellc_shared_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_core(resp_core), .resp_hit(resp_hit), .resp_uncached(resp_uncached),
        .resp_way(resp_way), .own_we(own_we), .own_group(own_group),
        .own_way(own_way), .own_core(own_core), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model: last-use time stamps order the ways.
    bit  m_valid [SETS][WAYS];
    int  m_tag   [SETS][WAYS];
    int  m_ts    [SETS][WAYS];
    int  m_owner [GROUPS][WAYS];
    int  m_hits  [CORES];
    int  m_miss  [CORES];
    int  m_clock = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void ref_access(input int core, input int addr,
                                       output bit hit, output bit unc, output int way);
        int idx, grp, tg, best;
        idx = addr % SETS; grp = idx / PER_GRP; tg = addr / SETS;
        hit = 0; unc = 0; way = -1;
        for (int w = 0; w < WAYS; w++)
            if (way < 0 && m_owner[grp][w] == core && m_valid[idx][w] && m_tag[idx][w] == tg) begin
                hit = 1; way = w;
            end
        if (!hit) begin
            for (int w = 0; w < WAYS; w++)
                if (way < 0 && m_owner[grp][w] == core && !m_valid[idx][w]) way = w;
            if (way < 0) begin
                best = 0;
                for (int w = 0; w < WAYS; w++)
                    if (m_owner[grp][w] == core && (way < 0 || m_ts[idx][w] < best)) begin
                        way = w; best = m_ts[idx][w];
                    end
            end
        end
        if (way < 0) begin
            unc = 1; way = 0;
            m_miss[core]++;
        end else begin
            m_clock++;
            m_ts[idx][way] = m_clock;
            if (!hit) begin m_valid[idx][way] = 1; m_tag[idx][way] = tg; end
            if (hit) m_hits[core]++; else m_miss[core]++;
        end
    endfunction

    task automatic wait_ready();
        int n = 0;
        while (!req_ready && n < 20) begin @(negedge clk); n++; end
    endtask

    // exp_way >= 0 adds a directed expectation on the way.
    task automatic access(input int core, input int addr, input string req, input int exp_way);
        bit eh, eu; int ew;
        wait_ready();
        ref_access(core, addr, eh, eu, ew);
        req_valid = 1; req_core = 2'(core); req_addr = ADDR_W'(addr);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        check(!req_ready && !resp_valid, "R7", "busy after accept", int'(req_ready), 0);
        @(posedge clk); @(negedge clk);
        check(resp_valid == 1'b1, "R7", "resp_valid", int'(resp_valid), 1);
        check(int'(resp_core) == core, "R7", "resp_core", int'(resp_core), core);
        check(resp_hit == eh, req, "resp_hit", int'(resp_hit), int'(eh));
        check(resp_uncached == eu, req, "resp_uncached", int'(resp_uncached), int'(eu));
        if (!eu) check(int'(resp_way) == ew, req, "resp_way", int'(resp_way), ew);
        if (exp_way >= 0) check(int'(resp_way) == exp_way, req, "directed way", int'(resp_way), exp_way);
        @(posedge clk); @(negedge clk);
        check(!resp_valid, "R7", "strobe one cycle", int'(resp_valid), 0);
    endtask

    task automatic set_owner(input int g, input int w, input int c);
        wait_ready();
        own_we = 1; own_group = 2'(g); own_way = 3'(w); own_core = 2'(c);
        @(posedge clk); @(negedge clk);
        own_we = 0;
        m_owner[g][w] = c;
    endtask

    task automatic check_counters(input string tagname);
        for (int c = 0; c < CORES; c++) begin
            check(int'(hit_cnt[c*CNT_W +: CNT_W]) == m_hits[c], "R8", {tagname, " hits"},
                  int'(hit_cnt[c*CNT_W +: CNT_W]), m_hits[c]);
            check(int'(miss_cnt[c*CNT_W +: CNT_W]) == m_miss[c], "R8", {tagname, " misses"},
                  int'(miss_cnt[c*CNT_W +: CNT_W]), m_miss[c]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_ts[s][w] = 0;
            end
        for (int g = 0; g < GROUPS; g++)
            for (int w = 0; w < WAYS; w++) m_owner[g][w] = w / (WAYS / CORES);   // R9
        for (int c = 0; c < CORES; c++) begin m_hits[c] = 0; m_miss[c] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
        check(hit_cnt == '0 && miss_cnt == '0, "R1", "counters zero", int'(|{hit_cnt, miss_cnt}), 0);

        // R9: core 1 owns ways 2,3 after reset; first fill lands in way 2 (R4).
        access(1, 1*SETS + 5, "R9", 2);
        access(1, 1*SETS + 5, "R3", 2);           // R3 hit
        access(0, 1*SETS + 5, "R3", 0);           // R3 isolation: core 0 misses into way 0
        access(1, 2*SETS + 5, "R4", 3);           // R4 second invalid way
        access(1, 1*SETS + 5, "R3", 2);           // touch way 2
        access(1, 3*SETS + 5, "R4", 3);           // R4 LRU evicts way 3
        access(1, 2*SETS + 5, "R4", 2);           // R4 LRU now way 2
        // R2: index 15 is group 0, index 16 group 1
        set_owner(1, 0, 3);
        access(3, 7*SETS + 16, "R2", 0);
        access(3, 7*SETS + 15, "R2", 6);
        access(3, 7*SETS + 16 + SETS, "R2", 6);   // different tag, same set
        // R6: hand way 0 of group 0 (holds tag 1 idx 5 for core 0) to core 2
        set_owner(0, 0, 2);
        access(2, 1*SETS + 5, "R6", 0);           // new owner hits kept line
        access(0, 1*SETS + 5, "R6", 1);           // core 0 now only has way 1
        // R5: strip core 3 of group 3
        for (int w = 0; w < WAYS; w++) set_owner(3, w, 0);
        access(3, 4*SETS + 50, "R5", -1);
        access(3, 4*SETS + 50, "R5", -1);
        access(0, 4*SETS + 50, "R5", 0);          // core 0 fills way 0 of group 3
        check_counters("directed");

        // Random mix of accesses and ownership writes.
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 7) == 0)
                set_owner($urandom_range(0, GROUPS-1), $urandom_range(0, WAYS-1),
                          $urandom_range(0, CORES-1));
            access($urandom_range(0, CORES-1),
                   $urandom_range(0, 5) * SETS + $urandom_range(0, SETS-1), "R3/R4/R5", -1);
        end
        check_counters("random");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule